// File: doc/BRIEF.md
# Breakpoint and watchpoint match unit

This block sits beside a CPU pipeline and watches two streams at once: the instruction fetch address and the data accesses. It holds four instruction breakpoint registers, four data watchpoint registers and one shared debug control register. All nine are loaded through a single write port that carries a bank select, an index and a 32-bit data word. There is no read path.

Each cycle the block does two things. It compares the fetch address with every enabled breakpoint. It also compares the data access address with every watchpoint whose access type matches the direction of the access. The result is a combinational hit flag, a cause code and the index of the matching unit, which the pipeline uses to raise a debug exception.

A write that hits a watchpoint is flagged in the same cycle, before it takes effect, and its commit enable is withdrawn. This stops the store from reaching memory. When both a fetch and a data access hit in the same cycle, the watchpoint hit is the one reported.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every breakpoint, watchpoint and control register is zero. No fetch or access raises a hit, including one at address 0.
- R2: A breakpoint register holds the target address in bits [31:1], and bit 0 is its enable. It hits only when bit 0 is 1 and the fetch address equals the register value with bit 0 cleared. A fetch address with bit 0 set never matches.
- R3: The access type of watchpoint i is the control register field [2i+3:2i+2]. Watchpoints 0, 1, 2 and 3 use bits [3:2], [5:4], [7:6] and [9:8]. Changing one field changes only that watchpoint's behaviour.
- R4: The type encoding is: 0 disabled, 1 reads only, 2 writes only, 3 reads or writes. `acc_write` = 1 marks a write and 0 marks a read.
- R5: A watchpoint hits only when all 32 bits of the access address equal its register. A neighbouring byte address does not hit.
- R6: `acc_commit` is 1 when `acc_valid` is 1 and no watchpoint hits. It is 0 for any access that hits a watchpoint, so a store that hits is not committed.
- R7: `dbg_cause` is 0 for no hit, 1 for a breakpoint and 2 for a watchpoint. `dbg_hit` is 1 exactly when the cause is not 0.
- R8: When a breakpoint and a watchpoint hit in the same cycle, the cause is 2 and the index is the watchpoint's index.
- R9: Bank select 0 writes the control register, 1 a breakpoint and 2 a watchpoint. Bank 3 is ignored. A write with index 4 to 7 changes no register.
- R10: When several units of the reported class match, `dbg_index` gives the lowest-numbered one. It is 0 when there is no hit.
- R11: A register write affects compares only from the next cycle on. A compare in the same cycle as the write uses the old value. Rewriting a watchpoint address keeps the type already held in the control register.
- R12: Breakpoint hits appear only while `fetch_valid` is 1, and watchpoint hits only while `acc_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_bank | input | 2 | Bank select: 0 control, 1 breakpoint, 2 watchpoint, 3 none |
| csr_idx | input | 3 | Register index within the bank |
| csr_wdata | input | 32 | Write data |
| fetch_valid | input | 1 | Fetch address is valid |
| fetch_pc | input | 32 | Fetch address |
| acc_valid | input | 1 | Data access is valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Data access byte address |
| bp_hit | output | 1 | Some enabled breakpoint matches the fetch |
| wp_hit | output | 1 | Some watchpoint matches the access |
| dbg_hit | output | 1 | A debug exception should be raised |
| dbg_cause | output | 2 | 0 none, 1 breakpoint, 2 watchpoint |
| dbg_index | output | 2 | Index of the reporting unit |
| acc_commit | output | 1 | The access may take effect |

## Verification
The bench loads one configuration that covers the cases to be told apart:
- an enabled breakpoint and a disabled one;
- two breakpoints and two watchpoints on the same address;
- one watchpoint of each access type.

It then runs fetches and reads and writes against this configuration. Each vector separates one pair of cases:
- a match from an off-by-one address, or from a fetch address with bit 0 set;
- a read from a write on the same watchpoint;
- a lone fetch hit from a fetch that coincides with a data hit.

Directed steps then write an out-of-range index and check that no neighbour is aliased. They also check that a write is not seen by a compare in the same cycle, that a change to one control field moves only that watchpoint, and that a moved watchpoint address keeps its type.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_BKPT  = 2'd1,
      CAUSE_WATCH = 2'd2
   } cause_e;

   localparam logic [1:0] BANK_CTRL = 2'd0;
   localparam logic [1:0] BANK_BP   = 2'd1;
   localparam logic [1:0] BANK_WP   = 2'd2;

   // access type: bit 0 = reads, bit 1 = writes
   localparam int TYPE_W = 2;

endpackage

// File: rtl/dbg_lowest_sel.sv
module dbg_lowest_sel #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  mask_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);

   initial begin
      if (N < 1 || (1 << IW) < N) $error("dbg_lowest_sel: IW too small for N");
   end

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask_i[i]) idx_o = IW'(i);
      end
   end

   assign any_o = |mask_i;

endmodule

// File: rtl/dbg_bp_bank.sv
module dbg_bp_bank #(
   parameter int AW = 32,
   parameter int N  = 4,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [IW-1:0] wr_idx_i,
   input  logic [AW-1:0] wr_data_i,
   input  logic          fetch_valid_i,
   input  logic [AW-1:0] fetch_pc_i,
   output logic [N-1:0]  hit_mask_o
);

   localparam logic [IW-1:0] N_L = IW'(N);

   initial begin
      if ((1 << IW) < N) $error("dbg_bp_bank: index width too small");
   end

   logic [N-1:0][AW-1:0] bp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q <= '0;
      end else if (wr_en_i) begin
         for (int i = 0; i < N; i++) begin
            if (wr_idx_i == IW'(i)) bp_q[i] <= wr_data_i;
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_cmp
      logic armed;
      assign armed = bp_q[g][0];
      assign hit_mask_o[g] = fetch_valid_i && armed &&
                             (fetch_pc_i == {bp_q[g][AW-1:1], 1'b0});
   end

   // R9
   ign_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_idx_i >= N_L) |=> $stable(bp_q));

   // R11
   wr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_idx_i < N_L) |=> (bp_q[$past(wr_idx_i)] == $past(wr_data_i)));

endmodule

// File: rtl/dbg_wp_bank.sv
module dbg_wp_bank
   import dbg_match_pkg::*;
#(
   parameter int AW = 32,
   parameter int N  = 4,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ctrl_i,
   input  logic          wr_wp_i,
   input  logic [IW-1:0] wr_idx_i,
   input  logic [AW-1:0] wr_data_i,
   input  logic          acc_valid_i,
   input  logic          acc_write_i,
   input  logic [AW-1:0] acc_addr_i,
   output logic [N-1:0]  hit_mask_o
);

   localparam logic [IW-1:0] N_L = IW'(N);

   initial begin
      if (TYPE_W * (N + 1) > AW) $error("dbg_wp_bank: type fields exceed control width");
      if ((1 << IW) < N) $error("dbg_wp_bank: index width too small");
   end

   logic [AW-1:0]        ctrl_q;
   logic [N-1:0][AW-1:0] wp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         wp_q   <= '0;
      end else begin
         if (wr_ctrl_i) ctrl_q <= wr_data_i;
         if (wr_wp_i) begin
            for (int i = 0; i < N; i++) begin
               if (wr_idx_i == IW'(i)) wp_q[i] <= wr_data_i;
            end
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_cmp
      logic [TYPE_W-1:0] kind;
      logic              dir_ok;
      assign kind   = ctrl_q[TYPE_W*(g+1) +: TYPE_W];
      assign dir_ok = acc_write_i ? kind[1] : kind[0];
      assign hit_mask_o[g] = acc_valid_i && dir_ok && (acc_addr_i == wp_q[g]);
   end

   // R11
   keep_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_wp_i && !wr_ctrl_i) |=> $stable(ctrl_q));

   // R9
   wp_ign_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_wp_i && wr_idx_i >= N_L) |=> $stable(wp_q));

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
   import dbg_match_pkg::*;
#(
   parameter int AW     = 32,
   parameter int NUM_BP = 4,
   parameter int NUM_WP = 4,
   parameter int SEL_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_we,
   input  logic [1:0]       csr_bank,
   input  logic [SEL_W-1:0] csr_idx,
   input  logic [AW-1:0]    csr_wdata,
   input  logic             fetch_valid,
   input  logic [AW-1:0]    fetch_pc,
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic [AW-1:0]    acc_addr,
   output logic             bp_hit,
   output logic             wp_hit,
   output logic             dbg_hit,
   output logic [1:0]       dbg_cause,
   output logic [((NUM_BP > NUM_WP ? NUM_BP : NUM_WP) > 1 ? $clog2(NUM_BP > NUM_WP ? NUM_BP : NUM_WP) : 1)-1:0] dbg_index,
   output logic             acc_commit
);

   localparam int UNITS = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP;
   localparam int UW    = (UNITS > 1) ? $clog2(UNITS) : 1;

   initial begin
      if (NUM_BP < 1 || NUM_WP < 1) $error("dbg_match_unit: need at least one unit per bank");
   end

   logic [NUM_BP-1:0] bp_mask;
   logic [NUM_WP-1:0] wp_mask;
   logic [UW-1:0]     bp_idx, wp_idx;
   logic              bp_any, wp_any;
   cause_e            cause;

   dbg_bp_bank #(.AW(AW), .N(NUM_BP), .IW(SEL_W)) u_bp (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (csr_we && csr_bank == BANK_BP),
      .wr_idx_i     (csr_idx),
      .wr_data_i    (csr_wdata),
      .fetch_valid_i(fetch_valid),
      .fetch_pc_i   (fetch_pc),
      .hit_mask_o   (bp_mask)
   );

   dbg_wp_bank #(.AW(AW), .N(NUM_WP), .IW(SEL_W)) u_wp (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl_i  (csr_we && csr_bank == BANK_CTRL),
      .wr_wp_i    (csr_we && csr_bank == BANK_WP),
      .wr_idx_i   (csr_idx),
      .wr_data_i  (csr_wdata),
      .acc_valid_i(acc_valid),
      .acc_write_i(acc_write),
      .acc_addr_i (acc_addr),
      .hit_mask_o (wp_mask)
   );

   dbg_lowest_sel #(.N(NUM_BP), .IW(UW)) u_bp_sel (
      .mask_i(bp_mask), .any_o(bp_any), .idx_o(bp_idx)
   );

   dbg_lowest_sel #(.N(NUM_WP), .IW(UW)) u_wp_sel (
      .mask_i(wp_mask), .any_o(wp_any), .idx_o(wp_idx)
   );

   always_comb begin
      if (wp_any)      cause = CAUSE_WATCH;
      else if (bp_any) cause = CAUSE_BKPT;
      else             cause = CAUSE_NONE;
   end

   assign bp_hit     = bp_any;
   assign wp_hit     = wp_any;
   assign dbg_cause  = cause;
   assign dbg_hit    = cause != CAUSE_NONE;
   assign dbg_index  = wp_any ? wp_idx : (bp_any ? bp_idx : '0);
   assign acc_commit = acc_valid && !wp_any;

   // R8
   wp_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_hit && bp_hit) |-> (dbg_cause == 2'd2 && wp_mask[dbg_index]));

   // R12
   bp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit |-> fetch_valid);

   // R12
   wp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> acc_valid);

   // R6
   no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && wp_mask != '0) |-> !acc_commit);

   // R10
   low_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_hit && bp_hit) |-> (bp_mask[dbg_index] &&
         ((bp_mask & ((NUM_BP'(1) << dbg_index) - NUM_BP'(1))) == '0)));

endmodule

// File: tb/sim_dbg_match_unit.sv
`timescale 1ns/1ps
module sim_dbg_match_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [1:0]  csr_bank = 2'd0;
   logic [2:0]  csr_idx = 3'd0;
   logic [31:0] csr_wdata = '0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        bp_hit, wp_hit, dbg_hit, acc_commit;
   logic [1:0]  dbg_cause, dbg_index;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dbg_match_unit u0 (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_bank(csr_bank),
      .csr_idx(csr_idx), .csr_wdata(csr_wdata), .fetch_valid(fetch_valid),
      .fetch_pc(fetch_pc), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .bp_hit(bp_hit), .wp_hit(wp_hit), .dbg_hit(dbg_hit),
      .dbg_cause(dbg_cause), .dbg_index(dbg_index), .acc_commit(acc_commit)
   );

   typedef struct packed {
      logic        fv;
      logic [31:0] pc;
      logic        av;
      logic        aw;
      logic [31:0] addr;
      logic [5:0]  exp;   // {hit, cause[1:0], index[1:0], commit}
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 32'h1000, 1'b0, 1'b0, 32'h0,    6'b1_01_00_0}, // R2 enabled bp0
      '{1'b1, 32'h2000, 1'b0, 1'b0, 32'h0,    6'b0_00_00_0}, // R2 bp1 disabled
      '{1'b1, 32'h1001, 1'b0, 1'b0, 32'h0,    6'b0_00_00_0}, // R2 pc bit0 set
      '{1'b1, 32'h3000, 1'b0, 1'b0, 32'h0,    6'b1_01_10_0}, // R10 bp2 and bp3
      '{1'b0, 32'h1000, 1'b0, 1'b0, 32'h0,    6'b0_00_00_0}, // R12 fetch invalid
      '{1'b0, 32'h0,    1'b1, 1'b0, 32'h8000, 6'b1_10_00_0}, // R4 read on read wp
      '{1'b0, 32'h0,    1'b1, 1'b1, 32'h8000, 6'b0_00_00_1}, // R4 write on read wp
      '{1'b0, 32'h0,    1'b1, 1'b1, 32'h8004, 6'b1_10_01_0}, // R6 write hits, no commit
      '{1'b0, 32'h0,    1'b1, 1'b0, 32'h8004, 6'b0_00_00_1}, // R4 read on write wp
      '{1'b0, 32'h0,    1'b1, 1'b0, 32'h8008, 6'b1_10_10_0}, // R10 read on wp2/wp3
      '{1'b0, 32'h0,    1'b1, 1'b1, 32'h8008, 6'b1_10_10_0}, // R4 write on both-type
      '{1'b0, 32'h0,    1'b1, 1'b0, 32'h8001, 6'b0_00_00_1}, // R5 neighbour byte
      '{1'b1, 32'h1000, 1'b1, 1'b0, 32'h8000, 6'b1_10_00_0}, // R8 both hit
      '{1'b1, 32'h1000, 1'b1, 1'b1, 32'h8000, 6'b1_01_00_1}, // R7 only bp hits
      '{1'b0, 32'h0,    1'b0, 1'b0, 32'h8000, 6'b0_00_00_0}  // R12 access invalid
   };

   task automatic check(input string req, input logic [5:0] exp);
      logic [5:0] act;
      act = {dbg_hit, dbg_cause, dbg_index, acc_commit};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {hit,cause,idx,commit} actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic drive(input logic fv, input logic [31:0] pc, input logic av,
                        input logic aw, input logic [31:0] addr);
      fetch_valid = fv; fetch_pc = pc; acc_valid = av; acc_write = aw; acc_addr = addr;
   endtask

   task automatic csr_wr(input logic [1:0] bank, input logic [2:0] idx, input logic [31:0] data);
      @(negedge clk);
      csr_we = 1'b1; csr_bank = bank; csr_idx = idx; csr_wdata = data;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic probe(input string req, input logic fv, input logic [31:0] pc,
                        input logic av, input logic aw, input logic [31:0] addr,
                        input logic [5:0] exp);
      @(negedge clk);
      drive(fv, pc, av, aw, addr);
      #1 check(req, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state: nothing armed, even at address 0
      probe("R1", 1'b1, 32'h0, 1'b1, 1'b0, 32'h0, 6'b0_00_00_1);
      probe("R1", 1'b1, 32'h0, 1'b1, 1'b1, 32'h0, 6'b0_00_00_1);
      drive(1'b0, '0, 1'b0, 1'b0, '0);

      csr_wr(2'd1, 3'd0, 32'h1001);
      csr_wr(2'd1, 3'd1, 32'h2000);
      csr_wr(2'd1, 3'd2, 32'h3001);
      csr_wr(2'd1, 3'd3, 32'h3001);
      csr_wr(2'd2, 3'd0, 32'h8000);
      csr_wr(2'd2, 3'd1, 32'h8004);
      csr_wr(2'd2, 3'd2, 32'h8008);
      csr_wr(2'd2, 3'd3, 32'h8008);
      csr_wr(2'd0, 3'd0, 32'h0000_03E4); // R3 types: wp0=1 wp1=2 wp2=3 wp3=3

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i].fv, VECS[i].pc, VECS[i].av, VECS[i].aw, VECS[i].addr);
         #1 check($sformatf("R7 vector %0d", i), VECS[i].exp);
      end
      drive(1'b0, '0, 1'b0, 1'b0, '0);

      // R9 out-of-range index and bank 3 change nothing
      csr_wr(2'd1, 3'd4, 32'h5001);
      csr_wr(2'd2, 3'd4, 32'h9000);
      csr_wr(2'd3, 3'd0, 32'h0);
      probe("R9", 1'b1, 32'h1000, 1'b0, 1'b0, 32'h0, 6'b1_01_00_0);
      probe("R9", 1'b1, 32'h5000, 1'b0, 1'b0, 32'h0, 6'b0_00_00_0);
      probe("R9", 1'b0, 32'h0, 1'b1, 1'b0, 32'h8000, 6'b1_10_00_0);
      probe("R9", 1'b0, 32'h0, 1'b1, 1'b0, 32'h9000, 6'b0_00_00_1);

      // R11 a write is not seen by a compare in the same cycle
      @(negedge clk);
      csr_we = 1'b1; csr_bank = 2'd1; csr_idx = 3'd1; csr_wdata = 32'h2001;
      drive(1'b1, 32'h2000, 1'b0, 1'b0, 32'h0);
      #1 check("R11 same cycle", 6'b0_00_00_0);
      @(negedge clk);
      csr_we = 1'b0;
      #1 check("R11 next cycle", 6'b1_01_01_0);

      // R3 change only wp0's field to writes: control = 0x3E8
      csr_wr(2'd0, 3'd0, 32'h0000_03E8);
      probe("R3", 1'b0, 32'h0, 1'b1, 1'b1, 32'h8000, 6'b1_10_00_0);
      probe("R3", 1'b0, 32'h0, 1'b1, 1'b0, 32'h8000, 6'b0_00_00_1);
      probe("R3", 1'b0, 32'h0, 1'b1, 1'b1, 32'h8004, 6'b1_10_01_0);

      // R11 moved watchpoint keeps its type (wp1 writes only)
      csr_wr(2'd2, 3'd1, 32'h9000);
      probe("R11", 1'b0, 32'h0, 1'b1, 1'b1, 32'h9000, 6'b1_10_01_0);
      probe("R11", 1'b0, 32'h0, 1'b1, 1'b0, 32'h9000, 6'b0_00_00_1);
      probe("R11", 1'b0, 32'h0, 1'b1, 1'b1, 32'h8004, 6'b0_00_00_1);

      // R6 read hit also withholds commit
      probe("R6", 1'b0, 32'h0, 1'b1, 1'b0, 32'h8008, 6'b1_10_10_0);

      // R4 type 0 disables: clear all fields
      csr_wr(2'd0, 3'd0, 32'h0);
      probe("R4", 1'b0, 32'h0, 1'b1, 1'b1, 32'h8008, 6'b0_00_00_1);

      drive(1'b0, '0, 1'b0, 1'b0, '0);
      @(negedge clk);
      finish_run();
   end

endmodule